// File: doc/BRIEF.md
# Mode-Banked 32-bit Register File with Exception Capture

This block presents sixteen 32-bit architectural registers to a 32-bit execution state while keeping every value in a unified store of 64-bit physical registers. Register 15 is the program counter, and registers 0 to 14 hold general data. The current processor mode decides which physical entry an architectural index reaches. Fast-interrupt mode has its own copies of registers 8 to 14. Each of the interrupt, supervisor, abort and undefined modes has its own copies of registers 13 and 14. The hypervisor mode has its own copy of register 13 only. User and system modes use the shared set. The banked copies live in physical entries that no other index can address. Only the low 32 bits of a physical entry can be read or written.

The block has two combinational read ports and one write port, all indexed by architectural register number. It also has a current-status register, a port to read and write one saved-status slot chosen by mode, and an exception-entry strobe with a target mode. On exception entry the block copies the current status into the saved-status slot of the target mode. It also records the return address. For the hypervisor target, the address goes into a dedicated 64-bit return register with the upper half zero. For every other exception target, the address goes into that mode's banked register 14. The saved-status slots and the hypervisor return register are outside the general-register index space.

Top module: `bankrf_top`

## Requirements
- R1: After reset, every physical register, the status register, every saved-status slot and the hypervisor return register read as zero.
- R2: Reads are combinational and return the low 32 bits of the mapped physical register. A write takes effect at the clock edge. A legal write whose index matches a read index is forwarded, so that read returns the written data in the same cycle.
- R3: User (5'h10) and system (5'h1F) modes share one register set. Registers 0 to 7 and register 15 are shared by every legal mode.
- R4: Fast-interrupt mode (5'h11) reaches private copies of registers 8 to 14. Writing them changes nothing seen in user mode.
- R5: Interrupt (5'h12), supervisor (5'h13), abort (5'h17) and undefined (5'h1B) modes each reach a private register 13 and a private register 14.
- R6: Hypervisor mode (5'h1A) reaches a private register 13. Its register 14 is the user-mode register 14.
- R7: With any mode encoding other than the eight listed, illegalMode is 1 and both read ports return zero. A write in that cycle changes no register. With a legal mode, illegalMode is 0.
- R8: An exception entry whose target is fast-interrupt, interrupt, supervisor, abort, undefined or hypervisor copies the status value held before that clock edge into the target's saved-status slot. An exception entry to any other target changes no state.
- R9: An exception entry to a target other than hypervisor writes the return address into that target's banked register 14. If a general write to the same physical register happens in the same cycle, the exception wins.
- R10: An exception entry to hypervisor sets hypRetAddr to {32'h0, return address} and leaves every general register unchanged.
- R11: savedRdData shows the saved-status slot selected by savedMode, and savedWrEn writes that slot. A mode without a slot reads zero and ignores writes. If an exception capture and a saved-status write hit the same slot in the same cycle, the exception capture wins.
- R12: statusRd returns the status register, which statusWrEn loads at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeIn | input | 5 | Current processor mode encoding |
| illegalMode | output | 1 | High when modeIn is not a legal encoding |
| rdIdxA | input | 4 | Read port A architectural index |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 4 | Read port B architectural index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | General register write enable |
| wrIdx | input | 4 | Write architectural index |
| wrData | input | 32 | Write data |
| statusWrEn | input | 1 | Status register write enable |
| statusWrData | input | 32 | Status register write data |
| statusRd | output | 32 | Status register value |
| savedMode | input | 5 | Mode selecting a saved-status slot |
| savedWrEn | input | 1 | Saved-status write enable |
| savedWrData | input | 32 | Saved-status write data |
| savedRdData | output | 32 | Selected saved-status slot value |
| excEn | input | 1 | Exception-entry strobe |
| excMode | input | 5 | Target mode of the exception |
| excRetAddr | input | 32 | Return address to capture |
| hypRetAddr | output | 64 | Hypervisor return-address register |

## Verification
The hardest case to reach is a cycle where three things collide: an exception capture, a general write to the same banked register 14, and a saved-status write to the same slot, with a status write pending as well. The stimulus first loads a known status value. It then raises the exception strobe together with a new status write in one cycle, and checks that the saved slot holds the older value. Next it drives an exception to supervisor, a supervisor-mode write to register 14 and a supervisor saved-status write all in the same cycle. It then reads both results back through the normal ports to confirm that the exception wins each collision.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  localparam int ARCH_W    = 32;
  localparam int PHYS_W    = 64;
  localparam int ARCH_REGS = 16;
  localparam int PHYS_REGS = 32;
  localparam int SLOTS     = 6;
  localparam int AIDX_W    = $clog2(ARCH_REGS);
  localparam int PIDX_W    = $clog2(PHYS_REGS);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int MODE_W    = 5;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
    M_ABT = 5'h17, M_HYP = 5'h1A, M_UND = 5'h1B, M_SYS = 5'h1F
  } mode_e;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    return m inside {M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_HYP, M_UND, M_SYS};
  endfunction

  // {valid, slot}: fiq 0, irq 1, svc 2, abt 3, und 4, hyp 5
  function automatic logic [SLOT_W:0] slotOf(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return {1'b1, SLOT_W'(0)};
      M_IRQ:   return {1'b1, SLOT_W'(1)};
      M_SVC:   return {1'b1, SLOT_W'(2)};
      M_ABT:   return {1'b1, SLOT_W'(3)};
      M_UND:   return {1'b1, SLOT_W'(4)};
      M_HYP:   return {1'b1, SLOT_W'(5)};
      default: return '0;
    endcase
  endfunction

  // Physical layout: 0..15 shared, 16..22 fast-interrupt r8..r14,
  // 21+2*slot / 22+2*slot are banked r13 / r14 for slots 1..4, 31 is hyp r13.
  function automatic logic [PIDX_W-1:0] physOf(input logic [MODE_W-1:0] m,
                                                input logic [AIDX_W-1:0] idx);
    logic [SLOT_W:0] s;
    s = slotOf(m);
    if (idx < AIDX_W'(8) || idx == AIDX_W'(15)) return PIDX_W'(idx);
    if (m == M_FIQ) return PIDX_W'(8) + PIDX_W'(idx);
    if (idx == AIDX_W'(13) && s[SLOT_W]) return PIDX_W'(21) + PIDX_W'(2) * PIDX_W'(s[SLOT_W-1:0]);
    if (idx == AIDX_W'(14) && s[SLOT_W] && m != M_HYP)
      return PIDX_W'(22) + PIDX_W'(2) * PIDX_W'(s[SLOT_W-1:0]);
    return PIDX_W'(idx);
  endfunction

  typedef struct packed {
    logic [PIDX_W-1:0] physA;
    logic [PIDX_W-1:0] physB;
    logic [PIDX_W-1:0] physW;
    logic [PIDX_W-1:0] excLr;
    logic [SLOT_W-1:0] excSlot;
    logic [SLOT_W-1:0] savedSlot;
    logic              wrGo;
    logic              rdGate;
    logic              excGo;
    logic              excToHyp;
    logic              savedValid;
    logic              savedWrGo;
  } strobe_t;
endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
(
  input  logic [MODE_W-1:0] modeIn,
  input  logic [AIDX_W-1:0] rdIdxA,
  input  logic [AIDX_W-1:0] rdIdxB,
  input  logic              wrEn,
  input  logic [AIDX_W-1:0] wrIdx,
  input  logic              excEn,
  input  logic [MODE_W-1:0] excMode,
  input  logic [MODE_W-1:0] savedMode,
  input  logic              savedWrEn,
  output strobe_t           strobe,
  output logic              illegalMode
);
  logic            legal;
  logic [SLOT_W:0] excS;
  logic [SLOT_W:0] savS;

  always_comb begin
    legal = modeLegal(modeIn);
    excS  = slotOf(excMode);
    savS  = slotOf(savedMode);

    strobe.physA      = physOf(modeIn, rdIdxA);
    strobe.physB      = physOf(modeIn, rdIdxB);
    strobe.physW      = physOf(modeIn, wrIdx);
    strobe.excLr      = physOf(excMode, AIDX_W'(14));
    strobe.excSlot    = excS[SLOT_W-1:0];
    strobe.savedSlot  = savS[SLOT_W-1:0];
    strobe.wrGo       = wrEn && legal;
    strobe.rdGate     = legal;
    strobe.excGo      = excEn && excS[SLOT_W];
    strobe.excToHyp   = (excMode == M_HYP);
    strobe.savedValid = savS[SLOT_W];
    strobe.savedWrGo  = savedWrEn && savS[SLOT_W];
    illegalMode       = !legal;
  end
endmodule

// File: rtl/bankrf_datapath.sv
module bankrf_datapath
  import bankrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ARCH_W-1:0] wrData,
  input  logic              statusWrEn,
  input  logic [ARCH_W-1:0] statusWrData,
  input  logic [ARCH_W-1:0] savedWrData,
  input  logic [ARCH_W-1:0] excRetAddr,
  output logic [ARCH_W-1:0] rdDataA,
  output logic [ARCH_W-1:0] rdDataB,
  output logic [ARCH_W-1:0] statusRd,
  output logic [ARCH_W-1:0] savedRdData,
  output logic [PHYS_W-1:0] hypRetAddr
);
  localparam int HI_W = PHYS_W - ARCH_W;

  logic [PHYS_W-1:0] physRegs [PHYS_REGS];
  logic [ARCH_W-1:0] savedSlots [SLOTS];
  logic [ARCH_W-1:0] statusQ;
  logic [PHYS_W-1:0] hypRetQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++) physRegs[i] <= '0;
      for (int s = 0; s < SLOTS; s++) savedSlots[s] <= '0;
      statusQ <= '0;
      hypRetQ <= '0;
    end else begin
      if (strobe.wrGo) physRegs[strobe.physW] <= {{HI_W{1'b0}}, wrData};
      if (strobe.excGo && !strobe.excToHyp)
        physRegs[strobe.excLr] <= {{HI_W{1'b0}}, excRetAddr};
      if (strobe.excGo && strobe.excToHyp)
        hypRetQ <= {{HI_W{1'b0}}, excRetAddr};
      if (strobe.savedWrGo) savedSlots[strobe.savedSlot] <= savedWrData;
      if (strobe.excGo) savedSlots[strobe.excSlot] <= statusQ;
      if (statusWrEn) statusQ <= statusWrData;
    end
  end

  logic [1:0][PIDX_W-1:0] rdPhys;
  logic [1:0][ARCH_W-1:0] rdOut;
  assign rdPhys = {strobe.physB, strobe.physA};

  for (genvar p = 0; p < 2; p++) begin : g_rdPort
    always_comb begin
      if (!strobe.rdGate)
        rdOut[p] = '0;
      else if (strobe.wrGo && strobe.physW == rdPhys[p])
        rdOut[p] = wrData;
      else
        rdOut[p] = physRegs[rdPhys[p]][ARCH_W-1:0];
    end
  end

  assign rdDataA     = rdOut[0];
  assign rdDataB     = rdOut[1];
  assign statusRd    = statusQ;
  assign savedRdData = strobe.savedValid ? savedSlots[strobe.savedSlot] : '0;
  assign hypRetAddr  = hypRetQ;
endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeIn,
  output logic              illegalMode,
  input  logic [AIDX_W-1:0] rdIdxA,
  output logic [ARCH_W-1:0] rdDataA,
  input  logic [AIDX_W-1:0] rdIdxB,
  output logic [ARCH_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [AIDX_W-1:0] wrIdx,
  input  logic [ARCH_W-1:0] wrData,
  input  logic              statusWrEn,
  input  logic [ARCH_W-1:0] statusWrData,
  output logic [ARCH_W-1:0] statusRd,
  input  logic [MODE_W-1:0] savedMode,
  input  logic              savedWrEn,
  input  logic [ARCH_W-1:0] savedWrData,
  output logic [ARCH_W-1:0] savedRdData,
  input  logic              excEn,
  input  logic [MODE_W-1:0] excMode,
  input  logic [ARCH_W-1:0] excRetAddr,
  output logic [PHYS_W-1:0] hypRetAddr
);
  strobe_t strobe;

  bankrf_ctrl u_ctrl (
    .modeIn(modeIn), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .wrEn(wrEn),
    .wrIdx(wrIdx), .excEn(excEn), .excMode(excMode), .savedMode(savedMode),
    .savedWrEn(savedWrEn), .strobe(strobe), .illegalMode(illegalMode)
  );

  bankrf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .savedWrData(savedWrData), .excRetAddr(excRetAddr),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .statusRd(statusRd),
    .savedRdData(savedRdData), .hypRetAddr(hypRetAddr)
  );
endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker
  import bankrf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] modeIn,
  input logic              illegalMode,
  input logic [AIDX_W-1:0] rdIdxA,
  input logic [ARCH_W-1:0] rdDataA,
  input logic [ARCH_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [AIDX_W-1:0] wrIdx,
  input logic [ARCH_W-1:0] wrData,
  input logic [ARCH_W-1:0] statusRd,
  input logic [MODE_W-1:0] savedMode,
  input logic [ARCH_W-1:0] savedRdData,
  input logic              excEn,
  input logic [MODE_W-1:0] excMode,
  input logic [ARCH_W-1:0] excRetAddr,
  input logic [PHYS_W-1:0] hypRetAddr
);
  logic excSlotHit;
  assign excSlotHit = excEn && slotOf(excMode)[SLOT_W] && savedMode == excMode;

  AST_FWD_READ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !illegalMode && rdIdxA == wrIdx) |-> rdDataA == wrData); // R2

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |-> (rdDataA == '0 && rdDataB == '0)); // R7

  AST_SAVED_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    excSlotHit |=> (!$stable(savedMode) || savedRdData == $past(statusRd))); // R8

  AST_HYP_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (excEn && excMode == M_HYP) |=> hypRetAddr == {32'h0, $past(excRetAddr)}); // R10

  AST_HYP_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(excEn) |=> hypRetAddr[PHYS_W-1:ARCH_W] == '0); // R10
endmodule

bind bankrf_top bankrf_checker u_chk (.*);

// File: tb/bankrf_top_test.sv
module bankrf_top_test;
  import bankrf_pkg::*;

  logic clk = 1'b0;
  logic rstN;
  logic [4:0] modeIn;
  logic illegalMode;
  logic [3:0] rdIdxA, rdIdxB, wrIdx;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic wrEn, statusWrEn, savedWrEn, excEn;
  logic [31:0] statusWrData, statusRd, savedWrData, savedRdData, excRetAddr;
  logic [4:0] savedMode, excMode;
  logic [63:0] hypRetAddr;

  always #10 clk = ~clk;

  bankrf_top uut (.*);

  typedef enum int {P_RDA, P_RDB, P_SAVED, P_STATUS, P_HYP, P_ILL} port_e;
  typedef struct {port_e port; logic [63:0] exp; string tag;} item_t;
  item_t scoreQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic expectVal(input port_e p, input logic [63:0] e, input string tag);
    item_t it;
    it.port = p; it.exp = e; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = scoreQ.pop_front();
      case (it.port)
        P_RDA:    act = {32'h0, rdDataA};
        P_RDB:    act = {32'h0, rdDataB};
        P_SAVED:  act = {32'h0, savedRdData};
        P_STATUS: act = {32'h0, statusRd};
        P_HYP:    act = hypRetAddr;
        default:  act = {63'h0, illegalMode};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s port %0d actual %h expected %h", it.tag, it.port, act, it.exp);
      end
    end
  end

  initial begin
    rstN = 0; modeIn = M_USR; rdIdxA = 0; rdIdxB = 0; wrIdx = 0; wrData = 0; wrEn = 0;
    statusWrEn = 0; statusWrData = 0; savedMode = M_SVC; savedWrEn = 0; savedWrData = 0;
    excEn = 0; excMode = M_USR; excRetAddr = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    expectVal(P_RDA, 0, "R1"); expectVal(P_STATUS, 0, "R1");
    expectVal(P_HYP, 0, "R1"); expectVal(P_SAVED, 0, "R1"); expectVal(P_ILL, 0, "R1");
    // R2 forwarding and persistence
    tick; wrEn = 1; wrIdx = 3; wrData = 32'hA1; rdIdxA = 3; expectVal(P_RDA, 32'hA1, "R2");
    tick; wrEn = 0; rdIdxB = 3; expectVal(P_RDA, 32'hA1, "R2"); expectVal(P_RDB, 32'hA1, "R2");
    // R3 user and system share
    tick; modeIn = M_SYS; wrEn = 1; wrIdx = 13; wrData = 32'h5555;
    tick; wrEn = 0; modeIn = M_USR; rdIdxA = 13; expectVal(P_RDA, 32'h5555, "R3");
    // R4 fast-interrupt bank
    tick; modeIn = M_FIQ; wrEn = 1; wrIdx = 8; wrData = 32'hF8;
    tick; wrIdx = 14; wrData = 32'hF14;
    tick; wrEn = 0; rdIdxA = 8; rdIdxB = 14;
    expectVal(P_RDA, 32'hF8, "R4"); expectVal(P_RDB, 32'hF14, "R4");
    tick; modeIn = M_USR; expectVal(P_RDA, 0, "R4"); expectVal(P_RDB, 0, "R4");
    tick; modeIn = M_FIQ; rdIdxA = 3; expectVal(P_RDA, 32'hA1, "R3");
    // R5 pair-banked modes
    tick; modeIn = M_SVC; wrEn = 1; wrIdx = 13; wrData = 32'h5C13;
    tick; modeIn = M_ABT; wrIdx = 14; wrData = 32'hAB14;
    tick; wrEn = 0; modeIn = M_IRQ; rdIdxA = 13; rdIdxB = 14;
    expectVal(P_RDA, 0, "R5"); expectVal(P_RDB, 0, "R5");
    tick; modeIn = M_UND; expectVal(P_RDA, 0, "R5"); expectVal(P_RDB, 0, "R5");
    tick; modeIn = M_SVC; expectVal(P_RDA, 32'h5C13, "R5");
    tick; modeIn = M_ABT; expectVal(P_RDB, 32'hAB14, "R5");
    // R6 hypervisor banks r13 only
    tick; modeIn = M_HYP; wrEn = 1; wrIdx = 13; wrData = 32'h4713;
    tick; wrIdx = 14; wrData = 32'h4714;
    tick; wrEn = 0; modeIn = M_USR; rdIdxA = 14; rdIdxB = 13;
    expectVal(P_RDA, 32'h4714, "R6"); expectVal(P_RDB, 32'h5555, "R6");
    tick; modeIn = M_HYP; rdIdxA = 13; expectVal(P_RDA, 32'h4713, "R6");
    // R7 illegal mode
    tick; modeIn = 5'h15; rdIdxA = 3; wrEn = 1; wrIdx = 3; wrData = 32'hDEAD;
    expectVal(P_RDA, 0, "R7"); expectVal(P_ILL, 1, "R7");
    tick; wrEn = 0; modeIn = M_USR; expectVal(P_RDA, 32'hA1, "R7"); expectVal(P_ILL, 0, "R7");
    // R12 status
    tick; statusWrEn = 1; statusWrData = 32'h600001D3;
    tick; statusWrEn = 0; expectVal(P_STATUS, 32'h600001D3, "R12");
    // R8/R9 exception to interrupt with simultaneous status write
    tick; excEn = 1; excMode = M_IRQ; excRetAddr = 32'h80000040;
    statusWrEn = 1; statusWrData = 32'h11;
    tick; excEn = 0; statusWrEn = 0; savedMode = M_IRQ; modeIn = M_IRQ; rdIdxA = 14;
    expectVal(P_SAVED, 32'h600001D3, "R8"); expectVal(P_RDA, 32'h80000040, "R9");
    expectVal(P_STATUS, 32'h11, "R12");
    // R9/R11 three-way collision on supervisor
    tick; excEn = 1; excMode = M_SVC; excRetAddr = 32'h100;
    modeIn = M_SVC; wrEn = 1; wrIdx = 14; wrData = 32'h1234;
    savedMode = M_SVC; savedWrEn = 1; savedWrData = 32'hBEEF;
    tick; excEn = 0; wrEn = 0; savedWrEn = 0;
    expectVal(P_RDA, 32'h100, "R9"); expectVal(P_SAVED, 32'h11, "R11");
    // R11 saved-status port
    tick; savedMode = M_FIQ; savedWrEn = 1; savedWrData = 32'hF00D;
    tick; savedWrEn = 0; expectVal(P_SAVED, 32'hF00D, "R11");
    tick; savedMode = M_USR; savedWrEn = 1; savedWrData = 32'h77;
    tick; savedWrEn = 0; expectVal(P_SAVED, 0, "R11");
    // R10 hypervisor exception
    tick; excEn = 1; excMode = M_HYP; excRetAddr = 32'hFFFFFFFC; modeIn = M_USR;
    tick; excEn = 0; rdIdxA = 14; savedMode = M_HYP;
    expectVal(P_HYP, 64'h00000000FFFFFFFC, "R10"); expectVal(P_RDA, 32'h4714, "R10");
    expectVal(P_SAVED, 32'h11, "R8");
    // R8 exception to a target without a slot is ignored
    tick; excEn = 1; excMode = M_SYS; excRetAddr = 32'h55;
    tick; excEn = 0; modeIn = M_SYS; rdIdxB = 13;
    expectVal(P_RDA, 32'h4714, "R8"); expectVal(P_HYP, 64'h00000000FFFFFFFC, "R8");
    expectVal(P_RDB, 32'h5555, "R8");
    tick; tick;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule